// File: doc/BRIEF.md
# Wakeup External Interrupt Controller

This block gathers 28 external wakeup lines and turns each into a pending bit that software can mask. Every pair of adjacent lines shares one 4-bit trigger field. That field selects low level, high level, falling edge, rising edge or both edges. Each line is first passed through a two-flop synchronizer. Edge conditions are found by comparing the synchronized value with its value one cycle earlier.

The 28 lines drive four parent interrupt outputs. The split is uneven: lines 0 to 3, lines 4 to 11, lines 12 to 19 and lines 20 to 27. A parent output is high while any line in its range is pending and unmasked. Software takes the parent interrupt, reads the pending and mask registers to find the line, and clears the pending bit by writing a one to it.

The register bus is minimal. A write strobe, a 2-bit address and write data update a register in one cycle. Read data is registered: it shows the register selected by the address on the previous rising edge.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the mask register reads 0x0FFFFFFF and the pending register reads 0. Both trigger registers read 0 and all four parent outputs are low.
- R2: Trigger code 0 sets a line's pending bit while the synchronized line is low. Code 1 sets it while the line is high.
- R3: Trigger code 2 sets pending on a falling edge, code 4 on a rising edge and code 6 on either edge. A transition in the other direction does not set pending for codes 2 and 4.
- R4: Trigger codes 3, 5 and 7 to 15 never set a pending bit.
- R5: The register map is: address 0 holds the trigger fields for lines 0 to 15, address 1 for lines 16 to 27, address 2 the mask, address 3 the pending bits. Line n below 16 uses bits [4*(n/2)+3 : 4*(n/2)] of address 0. Line n of 16 or more uses bits [4*((n-16)/2)+3 : 4*((n-16)/2)] of address 1.
- R6: Pending bits are set whatever the mask holds. A mask bit at 1 keeps its line off the parent outputs, and a mask bit at 0 lets the line through.
- R7: Writing 1 to a bit at address 3 clears that pending bit. Writing 0 leaves it unchanged, and pending bits never clear without such a write.
- R8: While a level condition holds, its pending bit is set again every cycle. A clear therefore takes effect only after the level condition has gone away.
- R9: Parent output 0 covers lines 0 to 3, output 1 covers lines 4 to 11, output 2 covers lines 12 to 19 and output 3 covers lines 20 to 27. Each output is registered and high while any of its lines is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | 28 | Asynchronous external wakeup lines |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 4 | Grouped parent interrupt outputs |

## Verification
The trigger logic is driven with line transitions in both directions under every defined code and several undefined ones. This separates edge detection from level detection and shows that the direction filter of codes 2 and 4 works. The cases use lines in both trigger registers and at both ends of a shared field, which catches a wrong field offset or a wrong register split. One line is held at an active level while it is cleared, which tells a sticky level apart from an edge. Single lines are unmasked at each group boundary (3/4, 11/12, 19/20) to show which parent output each line reaches.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  localparam int NUM_LINES     = 28;
  localparam int NUM_GROUPS    = 4;
  localparam int CODE_W        = 4;
  localparam int LINES_PER_CFG = 16;
  localparam int CFG_LO_W      = (LINES_PER_CFG / 2) * CODE_W;
  localparam int CFG_HI_W      = ((NUM_LINES - LINES_PER_CFG + 1) / 2) * CODE_W;

  typedef enum logic [3:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  typedef enum logic [1:0] {
    REG_CFG_LO = 2'd0,
    REG_CFG_HI = 2'd1,
    REG_MASK   = 2'd2,
    REG_PEND   = 2'd3
  } reg_sel_e;

  // First line of each parent group; group g ends where group g+1 starts.
  function automatic int group_base(input int g);
    case (g)
      0: return 0;
      1: return 4;
      2: return 12;
      3: return 20;
      default: return NUM_LINES;
    endcase
  endfunction

  function automatic logic [NUM_LINES-1:0] group_span(input int g);
    logic [NUM_LINES-1:0] span;
    for (int i = 0; i < NUM_LINES; i++)
      span[i] = (i >= group_base(g)) && (i < group_base(g + 1));
    return span;
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int   WIDTH   = 28,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RST_VAL}};
      last <= {WIDTH{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      last <= chain[STAGES-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = last;
endmodule

// File: rtl/wk_trig_match.sv
module wk_trig_match
  import wake_irq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              cur,
  input  logic              prev,
  output logic              hit
);
  always_comb begin
    case (code)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_FALL: hit = prev & ~cur;
      TRIG_RISE: hit = ~prev & cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/wk_group_irq.sv
module wk_group_irq
  import wake_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  pend,
  input  logic [NUM_LINES-1:0]  mask,
  output logic [NUM_GROUPS-1:0] irq
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [NUM_LINES-1:0] SPAN = group_span(g);
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= |(pend & ~mask & SPAN);
    end
  end
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int   DATA_W      = 32,
  parameter int   SYNC_STAGES = 2,
  parameter logic SYNC_RST    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  wake_in,
  input  logic                  bus_wen,
  input  logic [1:0]            bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [CFG_LO_W-1:0]  cfg_lo_q;
  logic [CFG_HI_W-1:0]  cfg_hi_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] sync_cur;
  logic [NUM_LINES-1:0] sync_prev;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] clr;

  wk_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(wake_in), .q(sync_cur), .q_prev(sync_prev)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [CODE_W-1:0] code;
    if (n < LINES_PER_CFG) begin : g_lo
      assign code = cfg_lo_q[CODE_W*(n/2) +: CODE_W];
    end else begin : g_hi
      assign code = cfg_hi_q[CODE_W*((n-LINES_PER_CFG)/2) +: CODE_W];
    end
    wk_trig_match u_match (
      .code(code), .cur(sync_cur[n]), .prev(sync_prev[n]), .hit(hit[n])
    );
  end

  assign clr = (bus_wen && bus_addr == REG_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '1;
      pend_q   <= '0;
    end else begin
      if (bus_wen && bus_addr == REG_CFG_LO) cfg_lo_q <= bus_wdata[CFG_LO_W-1:0];
      if (bus_wen && bus_addr == REG_CFG_HI) cfg_hi_q <= bus_wdata[CFG_HI_W-1:0];
      if (bus_wen && bus_addr == REG_MASK)   mask_q   <= bus_wdata[NUM_LINES-1:0];
      // a live condition wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CFG_LO: bus_rdata <= DATA_W'(cfg_lo_q);
        REG_CFG_HI: bus_rdata <= DATA_W'(cfg_hi_q);
        REG_MASK:   bus_rdata <= DATA_W'(mask_q);
        default:    bus_rdata <= DATA_W'(pend_q);
      endcase
    end
  end

  wk_group_irq u_grp (
    .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q), .irq(irq_o)
  );
endmodule

// File: rtl/wake_irq_ctrl_chk.sv
module wake_irq_ctrl_chk
  import wake_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wen,
  input logic [1:0]            bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [NUM_LINES-1:0]  pend,
  input logic [NUM_LINES-1:0]  mask,
  input logic [NUM_GROUPS-1:0] irq
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1 && pend == '0 && irq == '0));

  assert_no_silent_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wen && bus_addr == 2'd3) |=> ((pend & $past(pend)) == $past(pend)));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == 2'd2) |=> (mask == $past(bus_wdata[NUM_LINES-1:0])));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam logic [NUM_LINES-1:0] SPAN = group_span(g);
    assert_grp_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      ((pend & ~mask & SPAN) == '0) |=> !irq[g]);
    assert_grp_fire_R9: assert property (@(posedge clk) disable iff (rst)
      ((pend & ~mask & SPAN) != '0) |=> irq[g]);
  end
endmodule

bind wake_irq_ctrl wake_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend_q), .mask(mask_q), .irq(irq_o)
);

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [27:0] wake_in = '1;
  logic        bus_wen = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] cfg_lo = '0;
  logic [31:0] cfg_hi = '0;

  always #5 clk = ~clk;

  wake_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wake_in(wake_in), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [4:0] line;
    logic [3:0] code;
    logic       pre;
    logic       post;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{5'd0,  4'd4,  1'b0, 1'b1, 1'b1},
    '{5'd3,  4'd4,  1'b1, 1'b0, 1'b0},
    '{5'd5,  4'd2,  1'b1, 1'b0, 1'b1},
    '{5'd9,  4'd2,  1'b0, 1'b1, 1'b0},
    '{5'd12, 4'd6,  1'b0, 1'b1, 1'b1},
    '{5'd15, 4'd6,  1'b1, 1'b0, 1'b1},
    '{5'd16, 4'd1,  1'b0, 1'b1, 1'b1},
    '{5'd19, 4'd0,  1'b1, 1'b0, 1'b1},
    '{5'd22, 4'd1,  1'b0, 1'b0, 1'b0},
    '{5'd25, 4'd3,  1'b0, 1'b1, 1'b0},
    '{5'd27, 4'd5,  1'b1, 1'b0, 1'b0},
    '{5'd26, 4'd7,  1'b0, 1'b1, 1'b0},
    '{5'd20, 4'd4,  1'b0, 1'b1, 1'b1},
    '{5'd2,  4'd15, 1'b1, 1'b0, 1'b0}
  };

  localparam logic [4:0] GRP_LINE [8] = '{5'd0, 5'd3, 5'd4, 5'd11, 5'd12, 5'd19, 5'd20, 5'd27};
  localparam logic [3:0] GRP_EXP  [8] = '{4'b0001, 4'b0001, 4'b0010, 4'b0010,
                                          4'b0100, 4'b0100, 4'b1000, 4'b1000};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // R5: field placement computed from the register map
  task automatic set_code(input int ln, input logic [3:0] code);
    if (ln < 16) begin
      cfg_lo[4*(ln/2) +: 4] = code;
      bus_write(2'd0, cfg_lo);
    end else begin
      cfg_hi[4*((ln-16)/2) +: 4] = code;
      bus_write(2'd1, cfg_hi);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(4);
    rst = 1'b0;

    // R1 reset state
    check(irq_o == 4'd0, "R1 irq after reset", 32'(irq_o), 32'd0);
    bus_read(2'd0, rd); check(rd == 32'd0, "R1 cfg lo reset", rd, 32'd0);
    bus_read(2'd1, rd); check(rd == 32'd0, "R1 cfg hi reset", rd, 32'd0);
    bus_read(2'd2, rd); check(rd == 32'h0FFFFFFF, "R1 mask reset", rd, 32'h0FFFFFFF);
    bus_read(2'd3, rd); check(rd == 32'd0, "R1 pending reset", rd, 32'd0);

    cfg_lo = 32'hFFFFFFFF; cfg_hi = 32'h00FFFFFF;
    bus_write(2'd0, cfg_lo);
    bus_write(2'd1, cfg_hi);
    bus_read(2'd1, rd); check(rd == 32'h00FFFFFF, "R5 cfg hi width", rd, 32'h00FFFFFF);

    // R2 R3 R4 R5: table of trigger cases
    for (int i = 0; i < 14; i++) begin
      int ln;
      ln = int'(VEC[i].line);
      set_code(ln, VEC[i].code);
      wake_in[ln] = VEC[i].pre;
      idle(6);
      bus_write(2'd3, 32'h0FFFFFFF);
      wake_in[ln] = VEC[i].post;
      idle(6);
      bus_read(2'd3, rd);
      check(rd[ln] == VEC[i].exp, $sformatf("R3 R2 R4 vector %0d line %0d code %0d", i, ln, VEC[i].code),
            32'(rd[ln]), 32'(VEC[i].exp));
      set_code(ln, 4'hF);
      wake_in[ln] = 1'b1;
      idle(6);
      bus_write(2'd3, 32'h0FFFFFFF);
    end

    // R7 R6 R9: write-one-to-clear on line 4
    set_code(4, 4'd4);
    wake_in[4] = 1'b0; idle(6);
    bus_write(2'd3, 32'h0FFFFFFF);
    wake_in[4] = 1'b1; idle(6);
    bus_read(2'd3, rd); check(rd[4] == 1'b1, "R3 rise sets line 4", 32'(rd[4]), 32'd1);
    bus_write(2'd3, 32'd0);
    bus_read(2'd3, rd); check(rd[4] == 1'b1, "R7 zero write keeps pending", 32'(rd[4]), 32'd1);
    check(irq_o == 4'd0, "R6 masked line stays off", 32'(irq_o), 32'd0);
    bus_write(2'd2, 32'h0FFFFFEF); idle(3);
    check(irq_o == 4'b0010, "R9 line 4 on output 1", 32'(irq_o), 32'h2);
    bus_write(2'd3, 32'h10); idle(3);
    bus_read(2'd3, rd); check(rd[4] == 1'b0, "R7 one write clears", 32'(rd[4]), 32'd0);
    check(irq_o == 4'd0, "R7 irq drops after clear", 32'(irq_o), 32'd0);
    bus_write(2'd2, 32'h0FFFFFFF);
    set_code(4, 4'hF);

    // R8 level condition re-sets pending
    set_code(13, 4'd1); idle(6);
    bus_write(2'd3, 32'h2000); idle(1);
    bus_read(2'd3, rd); check(rd[13] == 1'b1, "R8 clear while level active", 32'(rd[13]), 32'd1);
    wake_in[13] = 1'b0; idle(6);
    bus_write(2'd3, 32'h0FFFFFFF);
    bus_read(2'd3, rd); check(rd[13] == 1'b0, "R8 clear after level gone", 32'(rd[13]), 32'd0);
    set_code(13, 4'hF);
    wake_in[13] = 1'b1; idle(6);
    bus_write(2'd3, 32'h0FFFFFFF);

    // R6 pending set while masked
    set_code(27, 4'd0);
    wake_in[27] = 1'b0; idle(6);
    check(irq_o == 4'd0, "R6 masked low line no irq", 32'(irq_o), 32'd0);
    bus_read(2'd3, rd); check(rd[27] == 1'b1, "R6 masked line still pends", 32'(rd[27]), 32'd1);
    wake_in[27] = 1'b1; idle(6);
    bus_write(2'd3, 32'h0FFFFFFF);

    // R9 group boundaries, low-level trigger on all lines
    cfg_lo = '0; cfg_hi = '0;
    bus_write(2'd0, cfg_lo);
    bus_write(2'd1, cfg_hi);
    bus_write(2'd2, 32'd0);
    idle(4);
    check(irq_o == 4'd0, "R9 idle lines no irq", 32'(irq_o), 32'd0);
    for (int k = 0; k < 8; k++) begin
      int ln;
      ln = int'(GRP_LINE[k]);
      wake_in[ln] = 1'b0; idle(6);
      check(irq_o == GRP_EXP[k], $sformatf("R9 line %0d output", ln), 32'(irq_o), 32'(GRP_EXP[k]));
      wake_in[ln] = 1'b1; idle(6);
      bus_write(2'd3, 32'h0FFFFFFF); idle(4);
      check(irq_o == 4'd0, $sformatf("R9 line %0d released", ln), 32'(irq_o), 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule